// File: doc/BRIEF.md
# Multi-channel debounced interrupt detector

This block watches up to eight external input lines, which it never drives, and raises a single combined interrupt when a line has settled at its chosen level for long enough. Each line is first resynchronized into the system clock domain. It is then qualified by a per-channel debounce timer whose length is programmed in whole milliseconds, from 1 ms to 4000 ms. Short pulses and chatter restart the timer, so they never produce an event.

Each channel behaves as a one-shot. Software enables the channel, picks which level counts as active, loads the debounce length and arms the channel. When the channel qualifies, its pending bit is set and it disarms itself. It stays silent until software arms it again. Pending bits are cleared by writing ones. The interrupt output is asserted while any pending bit has its mask bit set.

The millisecond time base comes from a strobe at 32.768 kHz, synchronous to the system clock. A prescaler divides this strobe by 33. The prescaler and the channel timers only run while at least one channel is both enabled and armed. A `run` output reports this condition so that it can drive a clock gate for the counting logic.

Top module: `eic_debounce`

## Requirements
- R1: Each of the NCH (default 8) channels qualifies, times and reports independently of the others, each with its own debounce length.
- R2: Register 8+c holds the debounce length of channel c in milliseconds and resets to 1. A written value of 0 is stored as 1, and a value above 4000 is stored as 4000.
- R3: Once an enabled, armed channel's input rests at its active level, pending bit c is set no earlier than L ms after the change and no later than L+1 ms plus a few clock cycles after it, where L is the channel's debounce length.
- R4: A time at the active level shorter than 1 ms never produces an event. Leaving the active level before the length is reached restarts the timing from zero.
- R5: When a channel reports an event, it disarms. It produces no further event until a one is written to its bit of the arm register (address 4). Reading address 4 returns the armed bits.
- R6: Polarity bit c (address 1) set to 1 makes a high input active; set to 0, it makes a low input active. A channel held at the inactive level never fires.
- R7: Pending (address 3) is write-one-to-clear, and writing zeros leaves its bits unchanged. The mask register is at address 2. `irq` is high exactly when some pending bit has its mask bit set.
- R8: `run` is high exactly when some channel is both enabled (address 0) and armed. While it is low, the prescaler is held at zero. The millisecond tick is one in every 33 slow strobes.
- R9: After reset, the enable, polarity, mask, pending and armed registers read 0, every debounce length reads 1, and `irq` and `run` are low.
- R10: A channel whose enable bit is 0 never sets its pending bit, even when it is armed and its input is held active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| ext_in | input | NCH | External input lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt |
| run | output | 1 | Counting-logic active, usable as a clock-gate enable |

## Verification
The debounce path is driven with four kinds of input patterns:
- Clean steps to the active level at random debounce lengths and polarities, checked against an early and a late bound. These separate an off-by-one timer from a correct one.
- Glitches shorter than one tick, which must leave no trace.
- A long pulse with a brief dropout, which shows whether the timer restarts or only pauses.
- Two channels stepped at the same instant with different lengths, which exposes any sharing of timer state between channels.

Holding the input active after an event, then re-arming, separates one-shot behaviour from level-retriggering.

// File: rtl/eic_debounce.sv
module eic_debounce #(
  parameter int NCH   = 8,
  parameter int PRESC = 33,
  parameter int MAXDB = 4000,
  parameter int AW    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slow_en,
  input  logic [NCH-1:0] ext_in,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic           irq,
  output logic           run
);
  localparam int DBW = $clog2(MAXDB + 1);
  localparam int PW  = $clog2(PRESC);

  logic [NCH-1:0] s1, s2, en, pol, msk, pend, armed, act, lvl_ok, fire;
  logic [NCH-1:0][DBW-1:0] db, cnt;
  logic [PW-1:0] pre;
  logic tick;
  logic [DBW-1:0] wdb;

  assign act    = en & armed;
  assign run    = |act;
  assign tick   = run & slow_en & (pre == PW'(PRESC - 1));
  assign lvl_ok = ~(s2 ^ pol);
  assign irq    = |(pend & msk);
  assign wdb    = (wdata == 32'd0) ? DBW'(1) :
                  (wdata > 32'(MAXDB)) ? DBW'(MAXDB) : wdata[DBW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= ext_in;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         pre <= '0;
    else if (!run)      pre <= '0;
    else if (slow_en)   pre <= tick ? '0 : pre + 1'b1;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign fire[i] = tick & act[i] & lvl_ok[i] & (cnt[i] >= db[i]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                              cnt[i] <= '0;
      else if (!act[i] || !lvl_ok[i] || fire[i]) cnt[i] <= '0;
      else if (tick)                           cnt[i] <= cnt[i] + 1'b1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                              db[i] <= DBW'(1);
      else if (wr_en && addr == AW'(8 + i))    db[i] <= wdb;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en    <= '0;
      pol   <= '0;
      msk   <= '0;
      pend  <= '0;
      armed <= '0;
    end else begin
      if (wr_en && addr == AW'(0)) en  <= wdata[NCH-1:0];
      if (wr_en && addr == AW'(1)) pol <= wdata[NCH-1:0];
      if (wr_en && addr == AW'(2)) msk <= wdata[NCH-1:0];
      pend  <= (pend & ~((wr_en && addr == AW'(3)) ? wdata[NCH-1:0] : '0)) | fire;
      armed <= (armed & ~fire) | ((wr_en && addr == AW'(4)) ? wdata[NCH-1:0] : '0);
    end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(0): rdata = 32'(en);
      AW'(1): rdata = 32'(pol);
      AW'(2): rdata = 32'(msk);
      AW'(3): rdata = 32'(pend);
      AW'(4): rdata = 32'(armed);
      default: ;
    endcase
    for (int i = 0; i < NCH; i++)
      if (addr == AW'(8 + i)) rdata = 32'(db[i]);
  end
endmodule

module eic_debounce_chk #(
  parameter int NCH = 8, PRESC = 33, MAXDB = 4000, AW = 4, DBW = 12, PW = 6
) (
  input logic clk, rst_n, irq, run, tick, wr_en,
  input logic [AW-1:0] addr,
  input logic [NCH-1:0] pend, armed, en, msk,
  input logic [NCH-1:0][DBW-1:0] db,
  input logic [PW-1:0] pre
);
  p_pend_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) != '0) |-> $past(tick));
  p_pend_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(armed)) == '0));
  p_pend_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(en)) == '0));
  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en && addr == AW'(4))) |-> ((pend & ~$past(pend) & armed) == '0));
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre == '0));
  p_pre_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pre < PW'(PRESC));
  p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & msk) == '0) |-> !irq);
  for (genvar i = 0; i < NCH; i++) begin : g_db
    p_db_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (db[i] >= DBW'(1)) && (db[i] <= DBW'(MAXDB)));
  end
endmodule

bind eic_debounce eic_debounce_chk #(
  .NCH(NCH), .PRESC(PRESC), .MAXDB(MAXDB), .AW(AW), .DBW(DBW), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .run(run), .tick(tick), .wr_en(wr_en),
  .addr(addr), .pend(pend), .armed(armed), .en(en), .msk(msk), .db(db), .pre(pre)
);

// File: tb/sim_eic_debounce.sv
module sim_eic_debounce;
  localparam int NCH = 8;
  localparam int P = 33;

  logic clk = 0, rst_n = 0, slow_en = 1, wr_en = 0;
  logic [NCH-1:0] ext_in = '0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, run;
  int n_chk = 0, n_bad = 0;
  logic done = 0;

  always #10 clk = ~clk;

  eic_debounce u0 (.clk(clk), .rst_n(rst_n), .slow_en(slow_en), .ext_in(ext_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .run(run));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] clamp(logic [31:0] v);
    return (v == 0) ? 32'd1 : (v > 4000) ? 32'd4000 : v;
  endfunction

  task automatic setup(int ch, int len, bit pl, bit mk);
    ext_in[ch] = ~pl;
    wait_n(4);
    wr(4'(8 + ch), 32'(len));
    wr(1, 32'(pl) << ch);
    wr(2, 32'(mk) << ch);
    wr(3, 32'hFF);
    wr(0, 32'd1 << ch);
    wr(4, 32'd1 << ch);
  endtask

  task automatic step_event(int ch, int len, bit pl, bit mk);
    logic [31:0] v;
    setup(ch, len, pl, mk);
    wait_n((len + 2) * P);
    rd(3, v); check("R6 inactive level", v, 0);
    check("R8 run while armed", 32'(run), 1);
    @(negedge clk); ext_in[ch] = pl;
    wait_n(len * P - 3);
    rd(3, v); check("R3 not before L ms", v, 0);
    wait_n(40);
    rd(3, v); check("R3 fired by L+1 ms", v, 32'd1 << ch);
    check("R7 irq follows mask", 32'(irq), 32'(mk));
    rd(4, v); check("R5 disarmed", v, 0);
    check("R8 run low when idle", 32'(run), 0);
    wr(3, 32'h0);
    rd(3, v); check("R7 zero write keeps", v, 32'd1 << ch);
    wr(3, 32'd1 << ch);
    rd(3, v); check("R7 w1c", v, 0);
    ext_in[ch] = ~pl; wait_n(5); ext_in[ch] = pl;
    wait_n((len + 3) * P);
    rd(3, v); check("R5 one-shot", v, 0);
    wr(4, 32'd1 << ch);
    wait_n((len + 1) * P + 40);
    rd(3, v); check("R5 re-arm fires", v, 32'd1 << ch);
    ext_in[ch] = ~pl;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    wait_n(3); rst_n = 1; wait_n(2);
    // R9 reset state
    for (int a = 0; a < 5; a++) begin rd(4'(a), v); check("R9 reset reg", v, 0); end
    for (int c = 0; c < NCH; c++) begin rd(4'(8 + c), v); check("R9 reset length", v, 1); end
    check("R9 irq", 32'(irq), 0);
    check("R9 run", 32'(run), 0);
    // R2 clamping
    begin
      logic [31:0] vals [4] = '{32'd0, 32'd5000, 32'd4000, 32'd1234};
      for (int k = 0; k < 4; k++) begin
        wr(4'(8 + k), vals[k]); rd(4'(8 + k), v);
        check("R2 length clamp", v, clamp(vals[k]));
      end
    end
    // R6 R3 R5 R7 directed both polarities
    step_event(0, 1, 1'b1, 1'b1);
    step_event(7, 2, 1'b0, 1'b0);
    // R4 glitches shorter than 1 ms
    setup(3, 1, 1'b1, 1'b1);
    for (int k = 0; k < 6; k++) begin
      int L = 1 + ($urandom % 30);
      ext_in[3] = 1; wait_n(L); ext_in[3] = 0; wait_n(50);
      rd(3, v); check("R4 glitch ignored", v, 0);
    end
    // R4 restart on dropout
    wr(8 + 3, 3);
    ext_in[3] = 1; wait_n(2 * P); ext_in[3] = 0; wait_n(3); ext_in[3] = 1;
    wait_n(3 * P - 3);
    rd(3, v); check("R4 restart", v, 0);
    wait_n(40);
    rd(3, v); check("R4 fires after full hold", v, 32'h8);
    ext_in[3] = 0;
    // R10 disabled channel
    setup(5, 1, 1'b1, 1'b1);
    wr(0, 0);
    wr(4, 32'h20);
    ext_in[5] = 1; wait_n(5 * P);
    rd(3, v); check("R10 disabled", v, 0);
    check("R10 irq", 32'(irq), 0);
    check("R8 run needs enable", 32'(run), 0);
    ext_in[5] = 0;
    // R1 two channels together
    ext_in = '0; wait_n(4);
    wr(3, 32'hFF); wr(1, 32'h21); wr(2, 32'h21);
    wr(8, 1); wr(8 + 5, 4);
    wr(0, 32'h21); wr(4, 32'h21);
    @(negedge clk); ext_in = 8'h21;
    wait_n(2 * P + 40);
    rd(3, v); check("R1 short channel alone", v, 32'h01);
    wait_n(3 * P);
    rd(3, v); check("R1 both fired", v, 32'h21);
    ext_in = '0; wr(0, 0); wr(3, 32'hFF);
    // random steps
    for (int it = 0; it < 12; it++) begin
      int ch = $urandom % NCH;
      int len = 1 + ($urandom % 4);
      bit pl = 1'($urandom);
      bit mk = 1'($urandom);
      step_event(ch, len, pl, mk);
      wr(0, 0); ext_in = '0;
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule